// File: doc/BRIEF.md
# Block Cipher Register Front-End

This unit is the bus-facing control and data-buffer section placed in front of a 128-bit block cipher engine. Software or a DMA channel reaches four 32-bit data words through a single data register. A word pointer selects the word and steps forward after every access. The same four words hold the plaintext going in and the result coming out, so a finished operation overwrites its input in place.

An operation starts in one of two ways. In manual mode it starts when the start strobe is written. In automatic mode it starts by itself once four data words have been written, which suits streaming. The configuration register is protected while the unit is enabled. A completion flag, masked by an interrupt enable, drives the interrupt output. The flag clears on a write of one to it and also as a side effect of certain accesses.

The cipher engine is a stand-in with fixed latency. Its latency depends on the key size. Its result word i is the bitwise inverse of input word (i+1) mod 4.

Top module: `cipher_regfront`

Register map (word addresses on `addr_i`):

| Address | Register | Contents |
|---|---|---|
| 0 | CFG | bit0 soft reset (write only), bit1 enable, bits3:2 key size, bit4 automatic start, bit5 last-output mode |
| 1 | CTRL | bit0 start strobe (write only) |
| 2 | STAT | bit0 completion flag (write 1 to clear), bit1 busy |
| 3 | IRQEN | bit0 interrupt enable |
| 4 | PTR | bits1:0 word pointer |
| 5 | DATA | the data word selected by the pointer |

Key size codes: 0 = 128-bit, 1 = 192-bit, 2 or 3 = 256-bit.

## Requirements
- R1: After reset, CFG, STAT, IRQEN, PTR and every data word read as zero, and busy_o and irq_o are low.
- R2: A data access at address 5 reaches the word selected by PTR. After every data access, read or write, the pointer advances by one and wraps from 3 to 0. A write to PTR (address 4) sets the pointer, and a read of PTR returns it.
- R3: When an operation completes, data word i is replaced by the bitwise inverse of the input word (i+1) mod 4.
- R4: A DATA read issued while busy returns zero. A DATA write issued while busy is ignored, but the pointer still advances.
- R5: In manual mode (CFG bit4 = 0), writing CTRL bit0 = 1 while CFG bit1 (enable) is set starts an operation, and busy_o rises at that clock edge. The strobe has no effect in automatic mode or while the unit is disabled.
- R6: In automatic mode (CFG bit4 = 1, enable set), the fourth data write accepted since the last start triggers an operation at the edge of that write.
- R7: While enabled, a CFG write changes only the enable bit and the soft-reset action. Key size, automatic mode and last-output mode keep their values.
- R8: busy_o stays high for 57, 67 or 77 cycles for key size code 0, 1 or 2. Code 3 behaves like code 2.
- R9: The completion flag (STAT bit0) is set when an operation completes. Writing 1 to STAT bit0 clears it, and so does an accepted manual start.
- R10: With last-output mode off (CFG bit5 = 0), a DATA read clears the completion flag and a DATA write does not. With it on, a DATA write clears the flag and a DATA read does not.
- R11: A start request made while busy is ignored, and the running operation finishes at its original time.
- R12: irq_o equals the completion flag ANDed with IRQEN bit0.
- R13: Writing CFG bit0 = 1 returns all registers, the pointer and the data words to zero at that edge, and CFG bit0 always reads back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered, valid the cycle after a read request |
| busy_o | output | 1 | Operation in progress |
| irq_o | output | 1 | Completion interrupt |

## Verification
Read data is due one cycle after the request edge. The monitor therefore compares each queued expected value at the falling edge that follows the capture edge. busy_o rises at the same edge as the accepted start write, or the fourth automatic write. It falls exactly 57, 67 or 77 edges later, and the bench checks this by subtracting cycle-counter stamps, so accesses made during the run do not disturb the measurement. Flag, interrupt and side-effect results appear at the edge of the causing access, and the bench checks them at the following falling edge through STAT reads and irq_o.

// File: rtl/cipher_regfront_pkg.sv
package cipher_regfront_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CFG   = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_IRQEN = 3'd3;
  localparam logic [ADDR_W-1:0] A_PTR   = 3'd4;
  localparam logic [ADDR_W-1:0] A_DATA  = 3'd5;
  localparam int unsigned CFG_W = 6;

  typedef struct packed {
    logic       lod;
    logic       auto_st;
    logic [1:0] ksz;
    logic       en;
  } cfg_t;
endpackage

// File: rtl/cipher_regfront_cfg.sv
module cipher_regfront_cfg
  import cipher_regfront_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic             swrst_o,
  output cfg_t             cfg_o
);
  cfg_t cfg_q;

  assign swrst_o = wr_i && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (swrst_o) begin
      cfg_q <= '0;
    end else if (wr_i) begin
      cfg_q.en <= wdata_i[1];
      if (!cfg_q.en) begin
        cfg_q.ksz     <= wdata_i[3:2];
        cfg_q.auto_st <= wdata_i[4];
        cfg_q.lod     <= wdata_i[5];
      end
    end
  end

  assign cfg_o = cfg_q;

  // R7
  cfg_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_q.en && wr_i && !wdata_i[0] |=>
      cfg_q.ksz == $past(cfg_q.ksz) && cfg_q.auto_st == $past(cfg_q.auto_st) &&
      cfg_q.lod == $past(cfg_q.lod));

  // R13
  swrst_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swrst_o |=> cfg_q == '0);
endmodule

// File: rtl/cipher_regfront_buf.sv
module cipher_regfront_buf #(
  parameter int unsigned W = 32,
  parameter int unsigned N = 4,
  localparam int unsigned PW = $clog2(N)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                ptr_wr_i,
  input  logic [PW-1:0]       ptr_wdata_i,
  input  logic                acc_i,
  input  logic                wr_i,
  input  logic [W-1:0]        wdata_i,
  input  logic                load_i,
  input  logic [N-1:0][W-1:0] res_i,
  output logic [N-1:0][W-1:0] blk_o,
  output logic [PW-1:0]       ptr_o,
  output logic [W-1:0]        rword_o
);
  logic [PW-1:0] ptr_q;
  logic [N-1:0][W-1:0] blk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ptr_q <= '0;
    else if (clr_i)       ptr_q <= '0;
    else if (ptr_wr_i)    ptr_q <= ptr_wdata_i;
    else if (acc_i)       ptr_q <= (ptr_q == PW'(N-1)) ? '0 : ptr_q + 1'b1;
  end

  for (genvar i = 0; i < N; i++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               blk_q[i] <= '0;
      else if (clr_i)                            blk_q[i] <= '0;
      else if (load_i)                           blk_q[i] <= res_i[i];
      else if (wr_i && ptr_q == PW'(i))          blk_q[i] <= wdata_i;
    end
  end

  assign blk_o   = blk_q;
  assign ptr_o   = ptr_q;
  assign rword_o = blk_q[ptr_q];

  // R2
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && !ptr_wr_i && !clr_i |=>
      ptr_q == (($past(ptr_q) == PW'(N-1)) ? '0 : $past(ptr_q) + 1'b1));
endmodule

// File: rtl/cipher_regfront_stub.sv
module cipher_regfront_stub #(
  parameter int unsigned W        = 32,
  parameter int unsigned N        = 4,
  parameter int unsigned LAT_BASE = 57,
  parameter int unsigned LAT_STEP = 10,
  localparam int unsigned CNT_W   = $clog2(LAT_BASE + 2*LAT_STEP)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                start_i,
  input  logic [1:0]          ksz_i,
  input  logic [N-1:0][W-1:0] blk_i,
  output logic                busy_o,
  output logic                fin_o,
  output logic [N-1:0][W-1:0] res_o
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q, lat_m1;

  always_comb begin
    case (ksz_i)
      2'd0:    lat_m1 = CNT_W'(LAT_BASE - 1);
      2'd1:    lat_m1 = CNT_W'(LAT_BASE + LAT_STEP - 1);
      default: lat_m1 = CNT_W'(LAT_BASE + 2*LAT_STEP - 1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= lat_m1;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign fin_o  = busy_q && (cnt_q == '0);

  for (genvar i = 0; i < N; i++) begin : g_xf
    assign res_o[i] = ~blk_i[(i+1) % N];
  end

  // R8
  lat_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_q && !clr_i && ksz_i == 2'd0 |=> busy_q && cnt_q == CNT_W'(LAT_BASE - 1));

  // R11
  busy_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && start_i && !clr_i && cnt_q != '0 |=> busy_q && cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/cipher_regfront.sv
module cipher_regfront
  import cipher_regfront_pkg::*;
#(
  parameter int unsigned W        = 32,
  parameter int unsigned N        = 4,
  parameter int unsigned LAT_BASE = 57,
  parameter int unsigned LAT_STEP = 10,
  localparam int unsigned PW      = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  output logic              busy_o,
  output logic              irq_o
);
  logic wr, rd;
  logic wr_cfg, wr_ctrl, wr_stat, wr_irqen, wr_ptr, wr_data, rd_data, acc_data;
  logic clr, busy, fin, data_wr_ok, start_man, start_auto, start;
  logic done_q, irqen_q;
  logic [PW-1:0] auto_cnt_q, ptr;
  logic [W-1:0] rdata_q, rword;
  logic [N-1:0][W-1:0] blk, res;
  cfg_t cfg;

  assign wr       = req_i && we_i;
  assign rd       = req_i && !we_i;
  assign wr_cfg   = wr && addr_i == A_CFG;
  assign wr_ctrl  = wr && addr_i == A_CTRL;
  assign wr_stat  = wr && addr_i == A_STAT;
  assign wr_irqen = wr && addr_i == A_IRQEN;
  assign wr_ptr   = wr && addr_i == A_PTR;
  assign wr_data  = wr && addr_i == A_DATA;
  assign rd_data  = rd && addr_i == A_DATA;
  assign acc_data = req_i && addr_i == A_DATA;

  assign data_wr_ok = wr_data && !busy;
  assign start_man  = cfg.en && !cfg.auto_st && wr_ctrl && wdata_i[0] && !busy;
  assign start_auto = cfg.en && cfg.auto_st && data_wr_ok && auto_cnt_q == PW'(N-1);
  assign start      = start_man || start_auto;

  cipher_regfront_cfg u_cfg (
    .clk_i, .rst_ni, .wr_i(wr_cfg), .wdata_i(wdata_i[CFG_W-1:0]),
    .swrst_o(clr), .cfg_o(cfg)
  );

  cipher_regfront_buf #(.W(W), .N(N)) u_buf (
    .clk_i, .rst_ni, .clr_i(clr), .ptr_wr_i(wr_ptr), .ptr_wdata_i(wdata_i[PW-1:0]),
    .acc_i(acc_data), .wr_i(data_wr_ok), .wdata_i, .load_i(fin), .res_i(res),
    .blk_o(blk), .ptr_o(ptr), .rword_o(rword)
  );

  cipher_regfront_stub #(.W(W), .N(N), .LAT_BASE(LAT_BASE), .LAT_STEP(LAT_STEP)) u_eng (
    .clk_i, .rst_ni, .clr_i(clr), .start_i(start), .ksz_i(cfg.ksz), .blk_i(blk),
    .busy_o(busy), .fin_o(fin), .res_o(res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              auto_cnt_q <= '0;
    else if (clr || start)                    auto_cnt_q <= '0;
    else if (cfg.en && cfg.auto_st && data_wr_ok) auto_cnt_q <= auto_cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   done_q <= 1'b0;
    else if (clr)  done_q <= 1'b0;
    else if (fin)  done_q <= 1'b1;
    else if ((wr_stat && wdata_i[0]) || start_man ||
             (rd_data && !cfg.lod) || (wr_data && cfg.lod))
      done_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       irqen_q <= 1'b0;
    else if (clr)      irqen_q <= 1'b0;
    else if (wr_irqen) irqen_q <= wdata_i[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (clr)    rdata_q <= '0;
    else if (rd) begin
      case (addr_i)
        A_CFG:   rdata_q <= {{(W-CFG_W){1'b0}}, cfg.lod, cfg.auto_st, cfg.ksz, cfg.en, 1'b0};
        A_STAT:  rdata_q <= {{(W-2){1'b0}}, busy, done_q};
        A_IRQEN: rdata_q <= {{(W-1){1'b0}}, irqen_q};
        A_PTR:   rdata_q <= {{(W-PW){1'b0}}, ptr};
        A_DATA:  rdata_q <= busy ? '0 : rword;
        default: rdata_q <= '0;
      endcase
    end
  end

  assign rdata_o = rdata_q;
  assign busy_o  = busy;
  assign irq_o   = done_q && irqen_q;

  // R4
  busy_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data && busy |=> rdata_o == '0);

  // R9
  done_w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stat && wdata_i[0] && !fin |=> !done_q);

  // R6
  auto_go_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg.en && cfg.auto_st && wr_data && !busy && auto_cnt_q == PW'(N-1) |=> busy_o);

  // R5
  man_go_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg.en && !cfg.auto_st && wr_ctrl && wdata_i[0] && !busy |=> busy_o && !done_q);
endmodule

// File: tb/sim_cipher_regfront.sv
module sim_cipher_regfront;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic busy, irq;
  int unsigned n_chk = 0, n_err = 0, cyc = 0;
  logic rd_fire = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic [31:0] pa[4], pb[4], pc[4];

  always #10 clk = ~clk;

  cipher_regfront u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .busy_o(busy), .irq_o(irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    rd_fire <= req && !we;
  end

  // monitor: compare read data one cycle after each read request
  always @(negedge clk) begin
    if (rd_fire && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (rdata !== e) begin
        n_err++;
        $display("FAIL %s: rdata actual %h expected %h", t, rdata, e);
      end
    end
  end

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] e);
    n_chk++;
    if (act !== e) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", t, act, e);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_idle(input int unsigned t0, input int unsigned lat, input string t);
    while (busy) @(negedge clk);
    chk(t, cyc - t0, lat);
  endtask

  task automatic run_man(input int unsigned lat, input string t);
    int unsigned t0;
    wr(3'd1, 32'h1);
    t0 = cyc;
    chk({t, " busy rises"}, busy, 1);
    wait_idle(t0, lat, t);
  endtask

  task automatic load(input logic [31:0] v[4]);
    wr(3'd4, 0);
    for (int i = 0; i < 4; i++) wr(3'd5, v[i]);
  endtask

  task automatic read_xf(input logic [31:0] v[4], input string t);
    wr(3'd4, 0);
    for (int i = 0; i < 4; i++) rd(3'd5, ~v[(i+1)%4], t);
  endtask

  task automatic finish_run();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned t0;
    pa = '{32'h1111_0000, 32'h2222_0001, 32'h3333_0002, 32'h4444_0003};
    pb = '{32'hdead_beef, 32'h0bad_cafe, 32'h1234_5678, 32'h9abc_def0};
    pc = '{32'hffff_0000, 32'h0000_ffff, 32'ha5a5_5a5a, 32'h0f0f_f0f0};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1
    chk("R1 busy", busy, 0);
    chk("R1 irq", irq, 0);
    rd(3'd0, 0, "R1 cfg");
    rd(3'd2, 0, "R1 stat");
    rd(3'd3, 0, "R1 irqen");
    rd(3'd4, 0, "R1 ptr");
    rd(3'd5, 0, "R1 data");

    // R2
    wr(3'd4, 2);
    rd(3'd4, 2, "R2 ptr write");
    load(pa);
    rd(3'd4, 0, "R2 ptr wrap");
    for (int i = 0; i < 4; i++) rd(3'd5, pa[i], "R2 word order");
    rd(3'd4, 0, "R2 ptr after reads");

    // R5 R8 R3 R9 R10: manual, 128-bit
    wr(3'd1, 1);
    chk("R5 strobe while disabled", busy, 0);
    wr(3'd0, 32'h2);
    run_man(57, "R8 latency code0");
    rd(3'd2, 1, "R9 done set");
    read_xf(pa, "R3 result in place");
    rd(3'd2, 0, "R10 read clears done");

    // R7
    wr(3'd0, 32'h3A);
    rd(3'd0, 32'h2, "R7 fields locked");
    wr(3'd0, 32'h38);
    rd(3'd0, 32'h0, "R7 disable only");
    wr(3'd0, 32'h6);
    rd(3'd0, 32'h6, "R7 write when disabled");
    run_man(67, "R8 latency code1");
    wr(3'd0, 0); wr(3'd0, 32'hA);
    run_man(77, "R8 latency code2");
    wr(3'd0, 0); wr(3'd0, 32'hE);
    run_man(77, "R8 latency code3");

    // R9 w1c
    rd(3'd2, 1, "R9 done before clear");
    wr(3'd2, 1);
    rd(3'd2, 0, "R9 w1c");

    // R11 R4 R9 manual start clears
    wr(3'd0, 0); wr(3'd0, 32'h2);
    load(pb);
    run_man(57, "R8 prep");
    wr(3'd1, 1);
    t0 = cyc;
    rd(3'd2, 2, "R9 start clears done");
    wr(3'd1, 1);
    wr(3'd5, 32'h5555_5555);
    rd(3'd5, 0, "R4 read masked");
    wr(3'd1, 1);
    wait_idle(t0, 57, "R11 restart ignored");
    read_xf('{~pb[1], ~pb[2], ~pb[3], ~pb[0]}, "R4 write while busy ignored");

    // R6 automatic start
    wr(3'd0, 0); wr(3'd0, 32'h12);
    rd(3'd2, 0, "R6 idle before");
    wr(3'd4, 0);
    for (int i = 0; i < 3; i++) wr(3'd5, pc[i]);
    chk("R6 no start after 3 words", busy, 0);
    wr(3'd1, 1);
    chk("R5 strobe ignored in auto", busy, 0);
    wr(3'd5, pc[3]);
    t0 = cyc;
    chk("R6 start on 4th word", busy, 1);
    wait_idle(t0, 57, "R6 auto latency");
    read_xf(pc, "R6 auto result");

    // R10 last-output mode
    wr(3'd0, 0); wr(3'd0, 32'h22);
    load(pa);
    run_man(57, "R10 prep");
    rd(3'd5, ~pa[1], "R10 result word0");
    rd(3'd2, 1, "R10 read keeps done");
    wr(3'd5, 32'h77);
    rd(3'd2, 0, "R10 write clears done");

    // R12
    wr(3'd3, 1);
    run_man(57, "R12 prep");
    chk("R12 irq on", irq, 1);
    wr(3'd3, 0);
    chk("R12 irq masked", irq, 0);
    wr(3'd3, 1);
    chk("R12 irq unmasked", irq, 1);
    wr(3'd2, 1);
    chk("R12 irq after w1c", irq, 0);

    // R13
    wr(3'd4, 3);
    wr(3'd0, 32'h3F);
    rd(3'd0, 0, "R13 cfg");
    rd(3'd3, 0, "R13 irqen");
    rd(3'd4, 0, "R13 ptr");
    for (int i = 0; i < 4; i++) rd(3'd5, 0, "R13 data");
    chk("R13 busy", busy, 0);

    finish_run();
  end
endmodule